// File: doc/BRIEF.md
# Sample FIFO with Level Flags

This block is the per-channel sample buffer that sits between a capture engine and a host read port. The capture side pushes data words in one at a time. The host pops them in arrival order, and each pop lowers the occupancy counter by one. Four comparators watch the counter against levels that the host programs. They drive four status flags: almost empty, almost full, low limit and high limit.

If the buffer is full and a push arrives in a cycle with no pop, the word is discarded and a sticky overflow bit is raised. A clear command empties the buffer, returns the counter to zero and drops the overflow bit. The capacity is a parameter. The programmed levels may take any value from zero up to the capacity.

Top module: `sample_fifo`

## Requirements
- R1: After reset, `level` is 0, `overflow` is 0 and `rd_data` is 0.
- R2: Each accepted push raises `level` by one. Each pop of a non-empty buffer lowers `level` by one. Words leave in the order they arrived, and `rd_data` shows the popped word from the clock edge that follows the cycle in which `rd_en` was high.
- R3: A push and a pop in the same cycle on a non-empty buffer leave `level` unchanged.
- R4: A pop on an empty buffer sets `rd_data` to 0 and leaves `level` at 0.
- R5: A push into a full buffer with no pop in the same cycle is discarded. `level` stays at the capacity and `overflow` becomes 1.
- R6: Once set, `overflow` remains 1 until a clear command, whatever other traffic follows.
- R7: A cycle with `clear` high empties the buffer. It sets `level` to 0, `overflow` to 0 and `rd_data` to 0, and ignores any push or pop in that cycle.
- R8: `almost_empty` is 1 exactly when `level` is less than or equal to `ae_mark`.
- R9: `almost_full` is 1 exactly when `level` is greater than or equal to `af_mark`.
- R10: `low_limit` is 1 exactly when `level` is less than or equal to `lo_level`.
- R11: `high_limit` is 1 exactly when `level` is greater than or equal to `hi_level`.
- R12: When the buffer is full, a push and a pop in the same cycle both succeed. The oldest word is returned, the new word is stored, `level` stays at the capacity, and `overflow` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Empty the buffer and drop the overflow bit |
| wr_en | input | 1 | Push request from the capture engine |
| wr_data | input | WIDTH | Word to push |
| rd_en | input | 1 | Pop request from the host |
| rd_data | output | WIDTH | Last popped word (0 after an empty pop) |
| ae_mark | input | CW | Almost-empty level |
| af_mark | input | CW | Almost-full level |
| lo_level | input | CW | Low-limit level |
| hi_level | input | CW | High-limit level |
| level | output | CW | Current occupancy |
| almost_empty | output | 1 | level <= ae_mark |
| almost_full | output | 1 | level >= af_mark |
| low_limit | output | 1 | level <= lo_level |
| high_limit | output | 1 | level >= hi_level |
| overflow | output | 1 | Sticky lost-write indication |

## Verification
The bound checker checks on every cycle the counter arithmetic: increment on a lone push, no change when a push and a pop coincide, and a ceiling at the capacity. It also checks the zero result of an empty pop, the discard-and-flag rule for a push into a full buffer, the stickiness of overflow and the effect of clear. Data ordering and the four flag comparisons are left to the bench. Its queue-based model is compared with every output on every clock while the fill level sweeps across each programmed level, including levels set to zero and to the capacity.

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [CW-1:0]    ae_mark,
  input  logic [CW-1:0]    af_mark,
  input  logic [CW-1:0]    lo_level,
  input  logic [CW-1:0]    hi_level,
  output logic [CW-1:0]    level,
  output logic             almost_empty,
  output logic             almost_full,
  output logic             low_limit,
  output logic             high_limit,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  wire is_full = (level == CW'(DEPTH));
  wire rd_ok   = rd_en && (level != '0);
  wire wr_ok   = wr_en && (!is_full || rd_ok);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      overflow <= 1'b0;
      rd_data  <= '0;
    end else if (clear) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      overflow <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) rptr <= bump(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
      if (wr_en && !wr_ok) overflow <= 1'b1;
      if (rd_ok)      rd_data <= mem[rptr];
      else if (rd_en) rd_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!clear && wr_ok) mem[wptr] <= wr_data;
  end

  assign almost_empty = (level <= ae_mark);
  assign almost_full  = (level >= af_mark);
  assign low_limit    = (level <= lo_level);
  assign high_limit   = (level >= hi_level);
endmodule

// File: rtl/sample_fifo_chk.sv
module sample_fifo_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [CW-1:0]    level,
  input logic             overflow
);
  assert_level_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clear && level < CW'(DEPTH)) |=> level == $past(level) + CW'(1));

  assert_push_pop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !clear && level != '0) |=> level == $past(level));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !clear && level == '0) |=> (rd_data == '0 && level == '0));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clear && level == CW'(DEPTH)) |=> (overflow && level == CW'(DEPTH)));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (level == '0 && !overflow && rd_data == '0));
endmodule

bind sample_fifo sample_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .level(level), .overflow(overflow)
);

// File: tb/sample_fifo_test.sv
module sample_fifo_test;
  localparam int W = 16;
  localparam int D = 8;
  localparam int CW = $clog2(D + 1);

  logic clk = 0, rst_n = 0, clear = 0, wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [CW-1:0] ae_mark = 2, af_mark = 6, lo_level = 3, hi_level = 5, level;
  logic almost_empty, almost_full, low_limit, high_limit, overflow;

  int checks = 0, fails = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] m_rd = '0;
  logic m_ovf = 0;

  always #10 clk = ~clk;

  sample_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ae_mark(ae_mark), .af_mark(af_mark),
    .lo_level(lo_level), .hi_level(hi_level), .level(level),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .low_limit(low_limit), .high_limit(high_limit), .overflow(overflow)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    int n = q.size();
    cmp(tag, "level", level, n);
    cmp(tag, "rd_data", rd_data, m_rd);
    cmp(tag, "overflow", overflow, m_ovf);
    cmp("R8", "almost_empty", almost_empty, n <= ae_mark);
    cmp("R9", "almost_full", almost_full, n >= af_mark);
    cmp("R10", "low_limit", low_limit, n <= lo_level);
    cmp("R11", "high_limit", high_limit, n >= hi_level);
  endtask

  task automatic step(input string tag, input logic w, input logic [W-1:0] d,
                      input logic r, input logic c);
    bit rok, was_full;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; clear = c;
    @(posedge clk);
    #1;
    if (c) begin
      q.delete(); m_ovf = 0; m_rd = '0;
    end else begin
      was_full = (q.size() == D);
      rok = r && (q.size() != 0);
      if (r) m_rd = rok ? q.pop_front() : '0;
      if (w) begin
        if (!was_full || rok) q.push_back(d);
        else m_ovf = 1;
      end
    end
    compare_all(tag);
    @(negedge clk);
    wr_en = 0; rd_en = 0; clear = 0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    for (int i = 0; i < D; i++) step("R2", 1, W'(16'h100 + i), 0, 0);
    step("R5", 1, 16'hDEAD, 0, 0);
    step("R6", 0, 0, 1, 0);
    step("R6", 1, 16'h0200, 0, 0);
    step("R5", 1, 16'hBEEF, 0, 0);
    step("R12", 1, 16'h0300, 1, 0);
    step("R3", 1, 16'h0301, 1, 0);
    for (int i = 0; i < D + 2; i++) step("R2", 0, 0, 1, 0);
    step("R4", 0, 0, 1, 0);
    step("R7", 1, 16'h0400, 0, 1);
    step("R4", 1, 16'h0500, 1, 0);
    step("R2", 0, 0, 1, 0);

    ae_mark = 0; af_mark = D; lo_level = D; hi_level = 0;
    #1 compare_all("R8");
    for (int i = 0; i < D; i++) step("R9", 1, W'(16'h600 + i), 0, 0);
    ae_mark = D; af_mark = 0; lo_level = 0; hi_level = D;
    #1 compare_all("R11");
    step("R5", 1, 16'h0700, 0, 0);
    step("R7", 1, 16'h0701, 1, 1);
    step("R1", 0, 0, 1, 0);
    step("R10", 1, 16'h0800, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule